// File: doc/BRIEF.md
# Transceiver link adaptation sequencer

This block is the control engine that brings a serial Ethernet link back into service after a rate change. A `start` pulse makes it hold the transmit and receive soft resets. It then works through a fixed, ordered bring-up procedure. Each step is a single register write or read on a simple memory-mapped master port, and polling steps repeat a read until a completion pattern appears.

The procedure has these phases:
- The PMA is shut off and an analog reset is triggered.
- Four rate-reconfiguration writes go out. The targets are parameters.
- A per-lane staggered reset runs only for the four-lane variant.
- The PMA is re-enabled and the transmit reset is released.
- A configuration load is started and polled until it completes.
- Initial adaptation runs over internal loopback.
- Unless loopback-only operation was chosen, loopback is turned off, the sequencer waits for valid receive traffic, and initial adaptation runs a second time.
- Continuous adaptation is started, and only then is the receive reset released.

The lane variant and the loopback-only choice are captured when `start` is accepted. If the link drops after bring-up, the whole procedure runs again from the first step. Any polling step that outlasts the programmable cycle budget ends the run with an error and leaves both resets asserted.

Top module: `link_adapt_seq`

## Requirements
- R1: After synchronous reset, both soft resets are asserted and `busy`, `done`, `error`, `mm_write` and `mm_read` are low.
- R2: A `start` accepted in idle or done asserts both soft resets. The sequencer then issues these writes in this order:
  - PMA control (default address 0x00100) with data 0.
  - Analog reset (0x00104) with data 1.
  - Four reconfiguration writes, with defaults reference clock 0x00300←0x11, clock ratio 0x00304←0x22, phase slip 0x00308←0x33, datapath/FEC 0x0030C←0x44.
- R3: When `mode_quad` was 1 at start, one write of data 1 to stagger base 0x00400 plus the lane index follows the reconfiguration writes, for lanes 0 to 3 in order. With `mode_quad` 0 no such write is made.
- R4: Next comes a write of 1 to PMA control. `tx_soft_rst` falls after that write is accepted, so it is low before any configuration load, while `rx_soft_rst` stays high.
- R5: The configuration load writes 0x80 to address 0x40143. It then reads 0x40144 repeatedly until bit 0 of the returned data is 1.
- R6: Initial adaptation runs as three steps:
  - A write of 1 to loopback control (0x00108).
  - A write of 1 to the adaptation command register (0x00200).
  - Repeated reads of adaptation status (0x00204) until the data has code 0x0126 in bits 31:16 and 0x0B00 in bits 15:0, both required.
- R7: When `loopback_only` was 0 at start, the sequencer then:
  - writes 0 to loopback control;
  - waits while `rx_valid` is low, making no bus request;
  - runs the command write and status poll of R6 again.
- R8: When `loopback_only` was 1 at start, the steps of R7 are skipped.
- R9: The last write is 2 to the adaptation command register. After it is accepted, `rx_soft_rst` falls and `done` rises.
- R10: `done` stays high until a new `start` or `link_lost`. `link_lost` in done reasserts both resets on the next cycle and repeats the whole sequence with the captured mode settings.
- R11: A poll read that fails after `timeout_cycles` cycles in the polling step, or a wait for `rx_valid` that lasts that long, ends the run with these outputs: `error` high, both resets high, `busy` low and no further bus request. The next `start` clears `error`.
- R12: The master port has at most one transaction in flight. Address, data and strobe are held while `mm_waitreq` is high. A read completes on `mm_rdvalid`.
- R13: `busy` is high in every state except idle and done, and a `start` while busy has no effect on the write sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the bring-up sequence (accepted in idle or done) |
| mode_quad | input | 1 | 1 selects the four-lane variant with staggered reset |
| loopback_only | input | 1 | 1 keeps internal loopback and skips the second adaptation |
| rx_valid | input | 1 | Valid receive traffic is present |
| link_lost | input | 1 | Link dropped; restarts the sequence when in done |
| timeout_cycles | input | 16 | Cycle budget for each polling step |
| tx_soft_rst | output | 1 | Transmit soft reset, active high |
| rx_soft_rst | output | 1 | Receive soft reset, active high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Link brought up |
| error | output | 1 | A polling step timed out |
| mm_addr | output | 20 | Master port address |
| mm_wdata | output | 32 | Master port write data |
| mm_write | output | 1 | Write strobe |
| mm_read | output | 1 | Read strobe |
| mm_waitreq | input | 1 | Slave stall; command held while high |
| mm_rdata | input | 32 | Read data |
| mm_rdvalid | input | 1 | Read data valid pulse |

## Verification
The sequence is run in each combination that changes its path:
- single-lane with the full second adaptation;
- four-lane with loopback only;
- a link-loss restart during which the mode inputs are changed, to show that the captured settings are used.

Each run is checked against its expected write list, including the reset levels at every write. The status responder sends near-miss adaptation words (right code with wrong data, wrong code with right data) and several not-ready configuration reads, so the read counts show that both fields are compared and that bit 0 alone ends the load poll. Timeouts are forced once in an adaptation poll and once in the wait for receive traffic, and a clean run afterwards confirms that `error` clears.

// File: rtl/link_adapt_pkg.sv
package link_adapt_pkg;

    localparam int unsigned LA_ADDR_W   = 20;
    localparam int unsigned LA_DATA_W   = 32;
    localparam int unsigned RECFG_STEPS = 4;
    localparam int unsigned RECFG_IW    = $clog2(RECFG_STEPS);

    localparam logic [LA_ADDR_W-1:0] CFG_TRIG_ADDR   = 20'h40143;
    localparam logic [LA_ADDR_W-1:0] CFG_STAT_ADDR   = 20'h40144;
    localparam logic [LA_DATA_W-1:0] CFG_TRIG_DATA   = 32'h0000_0080;
    localparam logic [15:0]          ADAPT_DONE_CODE = 16'h0126;
    localparam logic [15:0]          ADAPT_DONE_DATA = 16'h0B00;
    localparam logic [LA_DATA_W-1:0] ADAPT_INIT_CMD  = 32'h1;
    localparam logic [LA_DATA_W-1:0] ADAPT_CONT_CMD  = 32'h2;

    typedef enum logic [4:0] {
        ST_IDLE, ST_PMA_OFF, ST_ARST, ST_RECFG, ST_STAGGER, ST_PMA_ON,
        ST_CFG_LOAD, ST_CFG_POLL, ST_LPBK_ON, ST_ADAPT1_CMD, ST_ADAPT1_POLL,
        ST_LPBK_OFF, ST_WAIT_RX, ST_ADAPT2_CMD, ST_ADAPT2_POLL, ST_CONT_CMD,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {M_IDLE, M_CMD, M_RESP} mst_state_e;

    typedef struct packed {
        logic                 active;
        logic                 wr;
        logic [LA_ADDR_W-1:0] addr;
        logic [LA_DATA_W-1:0] data;
    } bus_op_t;

    function automatic logic adapt_complete(input logic [LA_DATA_W-1:0] rd);
        return (rd[31:16] == ADAPT_DONE_CODE) && (rd[15:0] == ADAPT_DONE_DATA);
    endfunction

    function automatic logic is_poll_state(input seq_state_e s);
        return (s == ST_CFG_POLL) || (s == ST_ADAPT1_POLL) ||
               (s == ST_WAIT_RX)  || (s == ST_ADAPT2_POLL);
    endfunction

endpackage

// File: rtl/link_poll_timer.sv
module link_poll_timer
    import link_adapt_pkg::*;
#(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          en,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    localparam logic [TW-1:0] CNT_MAX = '1;

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (en && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt >= limit);

    // R11: the window counter never moves outside a polling step
    assert_timer_idle_R11: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0));

endmodule

// File: rtl/link_bus_master.sv
module link_bus_master
    import link_adapt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  bus_op_t              op,
    output logic                 ack,
    output logic [LA_DATA_W-1:0] ack_data,
    output logic [LA_ADDR_W-1:0] mm_addr,
    output logic [LA_DATA_W-1:0] mm_wdata,
    output logic                 mm_write,
    output logic                 mm_read,
    input  logic                 mm_waitreq,
    input  logic [LA_DATA_W-1:0] mm_rdata,
    input  logic                 mm_rdvalid
);
    mst_state_e mst;

    always_ff @(posedge clk) begin
        if (rst) begin
            mst      <= M_IDLE;
            mm_addr  <= '0;
            mm_wdata <= '0;
            mm_write <= 1'b0;
            mm_read  <= 1'b0;
        end else begin
            unique case (mst)
                M_IDLE: if (op.active) begin
                    mm_addr  <= op.addr;
                    mm_wdata <= op.data;
                    mm_write <= op.wr;
                    mm_read  <= !op.wr;
                    mst      <= M_CMD;
                end
                M_CMD: if (!mm_waitreq) begin
                    mm_write <= 1'b0;
                    mm_read  <= 1'b0;
                    mst      <= mm_write ? M_IDLE : M_RESP;
                end
                M_RESP: if (mm_rdvalid) mst <= M_IDLE;
                default: mst <= M_IDLE;
            endcase
        end
    end

    assign ack      = ((mst == M_CMD) && mm_write && !mm_waitreq) ||
                      ((mst == M_RESP) && mm_rdvalid);
    assign ack_data = mm_rdata;

    assert_one_strobe_R12: assert property (@(posedge clk) disable iff (rst)
        !(mm_write && mm_read));

    assert_hold_stall_R12: assert property (@(posedge clk) disable iff (rst)
        ((mm_write || mm_read) && mm_waitreq) |=>
            ($stable(mm_addr) && $stable(mm_wdata) &&
             $stable(mm_write) && $stable(mm_read)));

    assert_no_new_cmd_R12: assert property (@(posedge clk) disable iff (rst)
        (mst == M_RESP) |-> !(mm_write || mm_read));

endmodule

// File: rtl/link_step_decode.sv
module link_step_decode
    import link_adapt_pkg::*;
#(
    parameter int unsigned IW = 2,
    parameter logic [LA_ADDR_W-1:0] PMA_CTL_ADDR   = 20'h00100,
    parameter logic [LA_ADDR_W-1:0] ARST_ADDR      = 20'h00104,
    parameter logic [LA_ADDR_W-1:0] LPBK_ADDR      = 20'h00108,
    parameter logic [LA_ADDR_W-1:0] ADAPT_CMD_ADDR = 20'h00200,
    parameter logic [LA_ADDR_W-1:0] ADAPT_STAT_ADDR= 20'h00204,
    parameter logic [LA_ADDR_W-1:0] STAG_BASE      = 20'h00400,
    parameter logic [RECFG_STEPS-1:0][LA_ADDR_W-1:0] RECFG_ADDR =
        {20'h0030C, 20'h00308, 20'h00304, 20'h00300},
    parameter logic [RECFG_STEPS-1:0][LA_DATA_W-1:0] RECFG_DATA =
        {32'h44, 32'h33, 32'h22, 32'h11}
) (
    input  seq_state_e state,
    input  logic [IW-1:0] idx,
    output bus_op_t    op
);
    always_comb begin
        op = '{active: 1'b1, wr: 1'b1, addr: '0, data: '0};
        unique case (state)
            ST_PMA_OFF:     begin op.addr = PMA_CTL_ADDR;   op.data = 32'h0; end
            ST_ARST:        begin op.addr = ARST_ADDR;      op.data = 32'h1; end
            ST_RECFG:       begin
                op.addr = RECFG_ADDR[idx[RECFG_IW-1:0]];
                op.data = RECFG_DATA[idx[RECFG_IW-1:0]];
            end
            ST_STAGGER:     begin
                op.addr = STAG_BASE + LA_ADDR_W'(idx);
                op.data = 32'h1;
            end
            ST_PMA_ON:      begin op.addr = PMA_CTL_ADDR;   op.data = 32'h1; end
            ST_CFG_LOAD:    begin op.addr = CFG_TRIG_ADDR;  op.data = CFG_TRIG_DATA; end
            ST_CFG_POLL:    begin op.wr = 1'b0; op.addr = CFG_STAT_ADDR; end
            ST_LPBK_ON:     begin op.addr = LPBK_ADDR;      op.data = 32'h1; end
            ST_LPBK_OFF:    begin op.addr = LPBK_ADDR;      op.data = 32'h0; end
            ST_ADAPT1_CMD,
            ST_ADAPT2_CMD:  begin op.addr = ADAPT_CMD_ADDR; op.data = ADAPT_INIT_CMD; end
            ST_ADAPT1_POLL,
            ST_ADAPT2_POLL: begin op.wr = 1'b0; op.addr = ADAPT_STAT_ADDR; end
            ST_CONT_CMD:    begin op.addr = ADAPT_CMD_ADDR; op.data = ADAPT_CONT_CMD; end
            default:        op.active = 1'b0;
        endcase
    end
endmodule

// File: rtl/link_adapt_seq.sv
module link_adapt_seq
    import link_adapt_pkg::*;
#(
    parameter int unsigned TW    = 16,
    parameter int unsigned LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 mode_quad,
    input  logic                 loopback_only,
    input  logic                 rx_valid,
    input  logic                 link_lost,
    input  logic [TW-1:0]        timeout_cycles,
    output logic                 tx_soft_rst,
    output logic                 rx_soft_rst,
    output logic                 busy,
    output logic                 done,
    output logic                 error,
    output logic [LA_ADDR_W-1:0] mm_addr,
    output logic [LA_DATA_W-1:0] mm_wdata,
    output logic                 mm_write,
    output logic                 mm_read,
    input  logic                 mm_waitreq,
    input  logic [LA_DATA_W-1:0] mm_rdata,
    input  logic                 mm_rdvalid
);
    localparam int unsigned IDX_MAX = (LANES > RECFG_STEPS) ? LANES : RECFG_STEPS;
    localparam int unsigned IW      = $clog2(IDX_MAX);
    localparam logic [IW-1:0] RECFG_LAST = IW'(RECFG_STEPS - 1);
    localparam logic [IW-1:0] LANE_LAST  = IW'(LANES - 1);

    seq_state_e state;
    logic [IW-1:0] idx;
    logic cfg_quad, cfg_lpbk;
    logic ack, expired;
    logic [LA_DATA_W-1:0] ack_data;
    bus_op_t op;

    link_step_decode #(.IW(IW)) u_decode (
        .state (state),
        .idx   (idx),
        .op    (op)
    );

    link_bus_master u_master (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .ack       (ack),
        .ack_data  (ack_data),
        .mm_addr   (mm_addr),
        .mm_wdata  (mm_wdata),
        .mm_write  (mm_write),
        .mm_read   (mm_read),
        .mm_waitreq(mm_waitreq),
        .mm_rdata  (mm_rdata),
        .mm_rdvalid(mm_rdvalid)
    );

    link_poll_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (!is_poll_state(state)),
        .en     (is_poll_state(state)),
        .limit  (timeout_cycles),
        .expired(expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            idx         <= '0;
            cfg_quad    <= 1'b0;
            cfg_lpbk    <= 1'b0;
            tx_soft_rst <= 1'b1;
            rx_soft_rst <= 1'b1;
            error       <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (start || ((state == ST_DONE) && link_lost)) begin
                        if (start) begin
                            cfg_quad <= mode_quad;
                            cfg_lpbk <= loopback_only;
                        end
                        tx_soft_rst <= 1'b1;
                        rx_soft_rst <= 1'b1;
                        error       <= 1'b0;
                        idx         <= '0;
                        state       <= ST_PMA_OFF;
                    end
                end
                ST_PMA_OFF: if (ack) state <= ST_ARST;
                ST_ARST:    if (ack) begin idx <= '0; state <= ST_RECFG; end
                ST_RECFG: if (ack) begin
                    if (idx == RECFG_LAST) begin
                        idx   <= '0;
                        state <= cfg_quad ? ST_STAGGER : ST_PMA_ON;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_STAGGER: if (ack) begin
                    if (idx == LANE_LAST) state <= ST_PMA_ON;
                    else                  idx   <= idx + 1'b1;
                end
                ST_PMA_ON: if (ack) begin
                    tx_soft_rst <= 1'b0;
                    state       <= ST_CFG_LOAD;
                end
                ST_CFG_LOAD: if (ack) state <= ST_CFG_POLL;
                ST_CFG_POLL: if (ack) begin
                    if (ack_data[0])  state <= ST_LPBK_ON;
                    else if (expired) begin
                        error <= 1'b1; tx_soft_rst <= 1'b1; rx_soft_rst <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_LPBK_ON:    if (ack) state <= ST_ADAPT1_CMD;
                ST_ADAPT1_CMD: if (ack) state <= ST_ADAPT1_POLL;
                ST_ADAPT1_POLL: if (ack) begin
                    if (adapt_complete(ack_data))
                        state <= cfg_lpbk ? ST_CONT_CMD : ST_LPBK_OFF;
                    else if (expired) begin
                        error <= 1'b1; tx_soft_rst <= 1'b1; rx_soft_rst <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_LPBK_OFF: if (ack) state <= ST_WAIT_RX;
                ST_WAIT_RX: begin
                    if (rx_valid) state <= ST_ADAPT2_CMD;
                    else if (expired) begin
                        error <= 1'b1; tx_soft_rst <= 1'b1; rx_soft_rst <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_ADAPT2_CMD: if (ack) state <= ST_ADAPT2_POLL;
                ST_ADAPT2_POLL: if (ack) begin
                    if (adapt_complete(ack_data)) state <= ST_CONT_CMD;
                    else if (expired) begin
                        error <= 1'b1; tx_soft_rst <= 1'b1; rx_soft_rst <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_CONT_CMD: if (ack) begin
                    rx_soft_rst <= 1'b0;
                    state       <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE) && (state != ST_DONE);
    assign done = (state == ST_DONE);

    assert_rx_after_tx_R4: assert property (@(posedge clk) disable iff (rst)
        !rx_soft_rst |-> !tx_soft_rst);

    assert_done_released_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!tx_soft_rst && !rx_soft_rst));

    assert_error_safe_R11: assert property (@(posedge clk) disable iff (rst)
        error |-> (tx_soft_rst && rx_soft_rst && !busy && !done));

    assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (done && link_lost) |=> (tx_soft_rst && rx_soft_rst && busy));

    assert_no_req_in_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_RX) && $past(state == ST_WAIT_RX) |-> !(mm_write || mm_read));

endmodule

// File: tb/link_adapt_seq_tb.sv
module link_adapt_seq_tb;
    import link_adapt_pkg::*;

    typedef struct {
        logic [19:0] a;
        logic [31:0] d;
        logic        t;
        logic        r;
        string       req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 0, mode_quad = 0, loopback_only = 0, rx_valid = 0, link_lost = 0;
    logic [15:0] timeout_cycles = 16'd1000;
    logic tx_soft_rst, rx_soft_rst, busy, done, error;
    logic [19:0] mm_addr;
    logic [31:0] mm_wdata;
    logic mm_write, mm_read;
    logic mm_waitreq = 1'b0;
    logic [31:0] mm_rdata = '0;
    logic mm_rdvalid = 1'b0;

    int n_checks = 0, n_err = 0;
    exp_t q[$];

    int cfg_need = 0, adapt_need = 0;
    bit adapt_never = 0;
    int cfg_reads = 0, adapt_reads = 0, adapt_run_reads = 0, adapt_cmds = 0;
    bit lpbk_off_seen = 0;
    int wcnt = 0, pend = 0;
    logic [31:0] pend_data = '0;
    int cycles = 0;

    always #5 clk = ~clk;

    link_adapt_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .mode_quad(mode_quad),
        .loopback_only(loopback_only), .rx_valid(rx_valid), .link_lost(link_lost),
        .timeout_cycles(timeout_cycles), .tx_soft_rst(tx_soft_rst),
        .rx_soft_rst(rx_soft_rst), .busy(busy), .done(done), .error(error),
        .mm_addr(mm_addr), .mm_wdata(mm_wdata), .mm_write(mm_write), .mm_read(mm_read),
        .mm_waitreq(mm_waitreq), .mm_rdata(mm_rdata), .mm_rdvalid(mm_rdvalid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void push(input logic [19:0] a, input logic [31:0] d,
                                 input logic t, input logic r, input string req);
        exp_t e;
        e.a = a; e.d = d; e.t = t; e.r = r; e.req = req;
        q.push_back(e);
    endfunction

    // driver: expected writes up to and including the first adaptation command
    function automatic void push_prefix(input bit quad);
        push(20'h00100, 32'h0, 1, 1, "R2");
        push(20'h00104, 32'h1, 1, 1, "R2");
        push(20'h00300, 32'h11, 1, 1, "R2");
        push(20'h00304, 32'h22, 1, 1, "R2");
        push(20'h00308, 32'h33, 1, 1, "R2");
        push(20'h0030C, 32'h44, 1, 1, "R2");
        if (quad) for (int i = 0; i < 4; i++) push(20'h00400 + 20'(i), 32'h1, 1, 1, "R3");
        push(20'h00100, 32'h1, 1, 1, "R4");
        push(20'h40143, 32'h80, 0, 1, "R5");
        push(20'h00108, 32'h1, 0, 1, "R6");
        push(20'h00200, 32'h1, 0, 1, "R6");
    endfunction

    function automatic void push_tail(input bit lpbk);
        if (!lpbk) begin
            push(20'h00108, 32'h0, 0, 1, "R7");
            push(20'h00200, 32'h1, 0, 1, "R7");
        end
        push(20'h00200, 32'h2, 0, 1, "R9");
    endfunction

    // responder and monitor, one process at the falling edge
    always @(negedge clk) begin
        cycles++;
        mm_rdvalid = 1'b0;
        wcnt++;
        mm_waitreq = (wcnt % 3 == 1);
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin mm_rdvalid = 1'b1; mm_rdata = pend_data; end
        end
        if (!rst && mm_write && !mm_waitreq) begin
            if (mm_addr == 20'h00108 && mm_wdata == 32'h0) lpbk_off_seen = 1;
            if (mm_addr == 20'h00200 && mm_wdata == 32'h1) begin
                adapt_cmds++; adapt_run_reads = 0;
            end
            if (q.size() == 0) begin
                chk(0, "R2", "unexpected write addr", {12'h0, mm_addr}, 32'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(mm_addr == e.a, e.req, "write addr", {12'h0, mm_addr}, {12'h0, e.a});
                chk(mm_wdata == e.d, e.req, "write data", mm_wdata, e.d);
                chk({tx_soft_rst, rx_soft_rst} == {e.t, e.r}, e.req, "reset levels at write",
                    {30'h0, tx_soft_rst, rx_soft_rst}, {30'h0, e.t, e.r});
            end
        end
        if (!rst && mm_read && !mm_waitreq) begin
            pend = 2;
            if (mm_addr == 20'h40144) begin
                pend_data = (cfg_reads < cfg_need) ? 32'hFFFF_FFFE : 32'h1;
                cfg_reads++;
            end else begin
                if (adapt_never || adapt_run_reads < adapt_need)
                    pend_data = adapt_run_reads[0] ? 32'h0127_0B00 : 32'h0126_0A00;
                else
                    pend_data = 32'h0126_0B00;
                adapt_run_reads++;
                adapt_reads++;
            end
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cycles > 150000) begin
            n_err++;
            $display("FAIL R9 watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end(input int lim);
        for (int i = 0; i < lim; i++) begin
            if (done || error) break;
            @(negedge clk);
        end
    endtask

    task automatic reset_counts();
        cfg_reads = 0; adapt_reads = 0; adapt_cmds = 0; lpbk_off_seen = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_soft_rst && rx_soft_rst, "R1", "resets after reset", {tx_soft_rst, rx_soft_rst}, 3);
        chk(!busy && !done && !error, "R1", "flags after reset", {busy, done, error}, 0);
        chk(!mm_write && !mm_read, "R1", "bus idle after reset", {mm_write, mm_read}, 0);

        // single-lane, full second adaptation
        cfg_need = 3; adapt_need = 2; reset_counts();
        push_prefix(0); push_tail(0);
        mode_quad = 0; loopback_only = 0;
        pulse_start();
        chk(busy && tx_soft_rst && rx_soft_rst, "R13", "busy after start",
            {busy, tx_soft_rst, rx_soft_rst}, 7);
        repeat (4) @(negedge clk);
        pulse_start(); // ignored while busy
        for (int i = 0; i < 5000 && !lpbk_off_seen; i++) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(busy && !done && rx_soft_rst, "R7", "held waiting for rx_valid",
            {busy, done, rx_soft_rst}, 5);
        chk(adapt_cmds == 1, "R7", "no second adaptation before rx_valid", adapt_cmds, 1);
        rx_valid = 1'b1;
        wait_end(5000);
        rx_valid = 1'b0;
        chk(done && !busy, "R9", "done after bring-up", {done, busy}, 2);
        chk(!tx_soft_rst && !rx_soft_rst, "R9", "resets released", {tx_soft_rst, rx_soft_rst}, 0);
        chk(q.size() == 0, "R13", "write list complete", q.size(), 0);
        chk(cfg_reads == 4, "R5", "config status reads", cfg_reads, 4);
        chk(adapt_reads == 6, "R6", "adaptation status reads", adapt_reads, 6);
        repeat (20) @(negedge clk);
        chk(done, "R10", "done holds", done, 1);

        // four-lane, loopback only, started from done
        cfg_need = 0; adapt_need = 1; reset_counts();
        push_prefix(1); push_tail(1);
        mode_quad = 1; loopback_only = 1;
        pulse_start();
        wait_end(5000);
        chk(done, "R8", "done in loopback-only run", done, 1);
        chk(q.size() == 0, "R3", "stagger writes seen", q.size(), 0);
        chk(adapt_reads == 2 && cfg_reads == 1, "R8", "reads in loopback-only run",
            adapt_reads * 16 + cfg_reads, 33);

        // link loss restart with captured mode
        reset_counts();
        push_prefix(1); push_tail(1);
        mode_quad = 0; loopback_only = 0;
        link_lost = 1'b1; @(negedge clk); link_lost = 1'b0;
        chk(!done && busy && tx_soft_rst && rx_soft_rst, "R10", "restart on link loss",
            {done, busy, tx_soft_rst, rx_soft_rst}, 7);
        wait_end(5000);
        chk(done && q.size() == 0, "R10", "restart sequence complete", q.size(), 0);

        // timeout in adaptation poll
        reset_counts(); adapt_never = 1; timeout_cycles = 16'd40;
        push_prefix(0);
        loopback_only = 1;
        pulse_start();
        wait_end(5000);
        chk(error && !busy && !done, "R11", "error after poll timeout", {error, busy, done}, 4);
        chk(tx_soft_rst && rx_soft_rst, "R11", "resets held on error", {tx_soft_rst, rx_soft_rst}, 3);
        chk(q.size() == 0, "R11", "writes before timeout", q.size(), 0);
        repeat (10) @(negedge clk);
        chk(!mm_read && !mm_write, "R11", "no bus activity after error", {mm_read, mm_write}, 0);

        // recovery
        reset_counts(); adapt_never = 0; adapt_need = 0; timeout_cycles = 16'd1000;
        push_prefix(0); push_tail(1);
        pulse_start();
        chk(!error, "R11", "error cleared by start", error, 0);
        wait_end(5000);
        chk(done && q.size() == 0, "R11", "recovery run completes", q.size(), 0);

        // timeout waiting for receive traffic
        reset_counts(); timeout_cycles = 16'd40; loopback_only = 0;
        push_prefix(0); push(20'h00108, 32'h0, 0, 1, "R7");
        pulse_start();
        wait_end(5000);
        chk(error && !done, "R11", "error on rx_valid timeout", {error, done}, 2);
        chk(q.size() == 0 && adapt_cmds == 1, "R7", "no adaptation without traffic", adapt_cmds, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule